// File: doc/BRIEF.md
# Cascadable Presettable Four-Bit Counter

This block is a synchronous four-bit up counter with a parallel preset. A build-time parameter selects whether the count runs through the full binary range (0 to 15) or through one decimal digit (0 to 9). A second parameter selects whether the active-low clear acts at once or at the next rising clock edge.

Each rising edge applies one of four operations, chosen by a fixed priority: CLEAR (clear low), LOAD (load low), COUNT (both enables high), and HOLD (anything else). The only transitions are between count values. CLEAR goes to zero. LOAD goes to the data word. COUNT goes to the successor, or to zero when the count is at or beyond the terminal value. HOLD stays where it is.

Two count enables are provided. The parallel enable only gates counting. The trickle enable gates counting and also gates the carry output. Carry is combinational and is high while the trickle enable is high and the count sits at its terminal value. To build a wider counter, each stage's trickle enable is fed from the carry of the stage below. All stages then step on the same clock edge.

Top module: `presettable_counter`

## Requirements
- R1: Clear is active low. With ASYNC_CLR=1 the count becomes 0 as soon as clear goes low, without a clock edge. With ASYNC_CLR=0 the count becomes 0 on the first rising edge at which clear is low, and is unchanged before that edge.
- R2: When clear and load are both low at an edge, the result is 0. Clear takes priority over load, and load takes priority over counting.
- R3: When load is low and clear is high at a rising edge, the count takes the value of the data word, whatever the state of both enables.
- R4: A load pulse that returns high before the rising edge has no effect. That edge behaves as a normal count edge.
- R5: The count advances by one only when clear, load, the parallel enable and the trickle enable are all high. If either enable is low, the count holds.
- R6: With DECADE=0, counting runs 0, 1, …, 15 and then wraps to 0.
- R7: With DECADE=1, counting runs 0, 1, …, 9 and then wraps to 0.
- R8: With DECADE=1, after a load of any value from 10 to 15, the next count edge sets the count to 0.
- R9: Carry equals the trickle enable ANDed with (count equals terminal value). The terminal value is 15 when DECADE=0 and 9 when DECADE=1. The parallel enable has no influence on carry.
- R10: Two stages chained carry-to-trickle-enable step together. Binary stages form an 8-bit counter that wraps from 255 to 0. Decade stages form a two-digit counter that wraps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per ASYNC_CLR |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4 | Preset data word |
| en_par | input | 1 | Parallel count enable, active high |
| en_trk | input | 1 | Trickle count enable, active high; also gates carry |
| q | output | 4 | Current count |
| carry | output | 1 | Terminal-count carry for the next stage |

## Verification
Two pairs of functions can meet in the same cycle.

The first pair is clear and load. The bench holds both low into one edge, for both clear variants, and expects 0. It also sweeps every data word under all four enable combinations and expects the loaded value, not an increment.

The second pair is carry generation and counting in the next stage. Long chained runs are compared each cycle against an arithmetic model of (value + 1) mod 256 and mod 100. The chained runs confirm that the upper stage steps on exactly the edge at which the lower stage wraps.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } ctr_op_e;

endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_par,
    input  logic    en_trk,
    output ctr_op_e op
);

    // Fixed priority: clear, then load, then count, then hold.
    always_comb begin
        if (!clr_n)
            op = OP_CLEAR;
        else if (!load_n)
            op = OP_LOAD;
        else if (en_par && en_trk)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import ctr_pkg::*;
#(
    parameter int W        = 4,
    parameter int TERM_VAL = 15
) (
    input  ctr_op_e      op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] din,
    output logic [W-1:0] nxt
);

    localparam logic [W-1:0] TC = W'(TERM_VAL);

    // Values at or past the terminal count go to zero. This also pulls
    // illegal decade codes back into the sequence.
    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = (cur >= TC) ? '0 : cur + 1'b1;
            OP_HOLD:  nxt = cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_tc.sv
module ctr_tc #(
    parameter int W        = 4,
    parameter int TERM_VAL = 15
) (
    input  logic [W-1:0] cur,
    input  logic         en_trk,
    output logic         carry
);

    localparam logic [W-1:0] TC = W'(TERM_VAL);

    always_comb carry = en_trk && (cur == TC);

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
    import ctr_pkg::*;
#(
    parameter int W         = 4,
    parameter bit DECADE    = 1'b0,
    parameter bit ASYNC_CLR = 1'b0
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] q,
    output logic         carry
);

    localparam int            TERM_VAL = DECADE ? 9 : (1 << W) - 1;
    localparam logic [W-1:0]  TC       = W'(TERM_VAL);

    ctr_op_e      op;
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nxt;

    ctr_ctrl u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_par (en_par),
        .en_trk (en_trk),
        .op     (op)
    );

    ctr_step #(.W(W), .TERM_VAL(TERM_VAL)) u_step (
        .op  (op),
        .cur (cnt),
        .din (din),
        .nxt (cnt_nxt)
    );

    ctr_tc #(.W(W), .TERM_VAL(TERM_VAL)) u_tc (
        .cur    (cnt),
        .en_trk (en_trk),
        .carry  (carry)
    );

    // State register: the clear variant is picked at build time.
    generate
        if (ASYNC_CLR) begin : g_async_clr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n)
                    cnt <= '0;
                else
                    cnt <= cnt_nxt;
            end
        end else begin : g_sync_clr
            always_ff @(posedge clk) begin
                cnt <= cnt_nxt;
            end
        end
    endgenerate

    always_comb q = cnt;

    // Assertion support: becomes set once a clear has been seen.
    logic chk_armed = 1'b0;
    always_ff @(posedge clk) if (!clr_n) chk_armed <= 1'b1;

    generate
        if (ASYNC_CLR) begin : g_a_async
            p_async_clear_r1: assert property (@(posedge clk)
                !clr_n |-> (q == '0));
        end else begin : g_a_sync
            p_sync_clear_r1: assert property (@(posedge clk) disable iff (!chk_armed)
                !clr_n |=> (q == '0));
        end
    endgenerate

    p_load_capture_r3: assert property (@(posedge clk) disable iff (!clr_n || !chk_armed)
        !load_n |=> (q == $past(din)));

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n || !chk_armed)
        (load_n && !(en_par && en_trk)) |=> $stable(q));

    p_step_r6: assert property (@(posedge clk) disable iff (!clr_n || !chk_armed)
        (load_n && en_par && en_trk && q < TC) |=> (q == $past(q) + 1'b1));

    p_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n || !chk_armed)
        (load_n && en_par && en_trk && q >= TC) |=> (q == '0));

    p_carry_tc_r9: assert property (@(posedge clk) disable iff (!chk_armed)
        carry |-> (en_trk && q == TC));

endmodule

// File: tb/presettable_counter_tb.sv
module presettable_counter_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Binary chain, synchronous clear (u_dut low, u_bhi high)
    logic       b_clr_n = 1'b1, b_load_n = 1'b1, b_enp = 1'b0, b_ent = 1'b0;
    logic [3:0] b_din_lo = '0, b_din_hi = '0;
    logic [3:0] b_lo, b_hi;
    logic       b_c_lo, b_c_hi;

    // Decade chain, asynchronous clear
    logic       d_clr_n = 1'b1, d_load_n = 1'b1, d_enp = 1'b0, d_ent = 1'b0;
    logic [3:0] d_din_lo = '0, d_din_hi = '0;
    logic [3:0] d_lo, d_hi;
    logic       d_c_lo, d_c_hi;

    presettable_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_dut (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .din(b_din_lo),
        .en_par(b_enp), .en_trk(b_ent), .q(b_lo), .carry(b_c_lo));
    presettable_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_bhi (
        .clk(clk), .clr_n(b_clr_n), .load_n(b_load_n), .din(b_din_hi),
        .en_par(b_enp), .en_trk(b_c_lo), .q(b_hi), .carry(b_c_hi));
    presettable_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dlo (
        .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .din(d_din_lo),
        .en_par(d_enp), .en_trk(d_ent), .q(d_lo), .carry(d_c_lo));
    presettable_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_dhi (
        .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .din(d_din_hi),
        .en_par(d_enp), .en_trk(d_c_lo), .q(d_hi), .carry(d_c_hi));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One edge, then settle before sampling.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        #1;

        // R1 synchronous clear: zero on the edge
        b_clr_n = 1'b0;
        tick();
        b_clr_n = 1'b1;
        chk("R1 sync clear lo", b_lo, 0);
        chk("R1 sync clear hi", b_hi, 0);

        // R1: sync clear does nothing before the edge
        b_load_n = 1'b0; b_din_lo = 4'd5; b_din_hi = 4'd2;
        tick();
        b_load_n = 1'b1;
        b_clr_n = 1'b0;
        #1;
        chk("R1 sync clear waits for edge", b_lo, 5);
        tick();
        b_clr_n = 1'b1;
        chk("R1 sync clear at edge", b_lo, 0);

        // R2: clear and load together
        b_clr_n = 1'b0; b_load_n = 1'b0; b_din_lo = 4'd9;
        tick();
        b_clr_n = 1'b1; b_load_n = 1'b1;
        chk("R2 clear beats load", b_lo, 0);

        // R3: load every word under every enable combination
        for (int e = 0; e < 4; e++) begin
            for (int d = 0; d < 16; d++) begin
                b_enp = e[0]; b_ent = e[1];
                b_load_n = 1'b0; b_din_lo = 4'(d); b_din_hi = 4'(15 - d);
                tick();
                chk("R3 load lo", b_lo, d);
                chk("R3 load hi", b_hi, 15 - d);
            end
        end
        b_load_n = 1'b1;

        // R5/R9: enable combinations with the low stage at 15
        for (int e = 0; e < 4; e++) begin
            b_enp = 1'b0; b_ent = 1'b0;
            b_load_n = 1'b0; b_din_lo = 4'd15; b_din_hi = 4'd3;
            tick();
            b_load_n = 1'b1;
            b_enp = e[0]; b_ent = e[1];
            #1;
            chk("R9 carry follows trickle enable only", b_c_lo, e[1]);
            tick();
            chk("R5 enable gating lo", b_lo, (e == 3) ? 0 : 15);
            chk("R5 enable gating hi", b_hi, (e == 3) ? 4 : 3);
        end

        // R5: hold with one enable low at a mid value
        b_load_n = 1'b0; b_din_lo = 4'd6; b_din_hi = 4'd0;
        tick();
        b_load_n = 1'b1; b_enp = 1'b1; b_ent = 1'b0;
        tick();
        chk("R5 hold with trickle low", b_lo, 6);
        b_enp = 1'b0; b_ent = 1'b1;
        tick();
        chk("R5 hold with parallel low", b_lo, 6);

        // R4: a released load pulse does not matter
        b_enp = 1'b1; b_ent = 1'b1; b_din_lo = 4'd12;
        b_load_n = 1'b0;
        #1;
        b_load_n = 1'b1;
        tick();
        chk("R4 released load counts", b_lo, 7);

        // R6/R9/R10: 8-bit chained binary run through 255 -> 0
        b_clr_n = 1'b0;
        tick();
        b_clr_n = 1'b1;
        v = 0;
        for (int i = 0; i < 300; i++) begin
            chk("R9 binary carry", b_c_lo, (v % 16 == 15) ? 1 : 0);
            chk("R10 high carry at 255", b_c_hi, (v == 255) ? 1 : 0);
            tick();
            v = (v + 1) % 256;
            chk("R6 binary low stage", b_lo, v % 16);
            chk("R10 8-bit chain", {b_hi, b_lo}, v);
        end
        b_enp = 1'b0; b_ent = 1'b0;

        // R1 asynchronous clear: immediate, no edge
        d_load_n = 1'b0; d_din_lo = 4'd7; d_din_hi = 4'd4;
        tick();
        d_load_n = 1'b1;
        d_clr_n = 1'b0;
        #1;
        chk("R1 async clear lo", d_lo, 0);
        chk("R1 async clear hi", d_hi, 0);
        d_clr_n = 1'b1;

        // R2 for asynchronous build
        d_clr_n = 1'b0; d_load_n = 1'b0; d_din_lo = 4'd3;
        tick();
        d_clr_n = 1'b1; d_load_n = 1'b1;
        chk("R2 async clear beats load", d_lo, 0);

        // R8: illegal decade codes recover to 0
        for (int d = 10; d < 16; d++) begin
            d_load_n = 1'b0; d_din_lo = 4'(d); d_din_hi = 4'd0;
            d_enp = 1'b1; d_ent = 1'b1;
            tick();
            d_load_n = 1'b1;
            chk("R8 illegal code loaded", d_lo, d);
            tick();
            chk("R8 illegal code recovers", d_lo, 0);
            chk("R8 no spurious carry", d_hi, 0);
        end

        // R7/R9/R10: two-digit chained decade run through 99 -> 0
        d_clr_n = 1'b0;
        #1;
        d_clr_n = 1'b1;
        v = 0;
        for (int i = 0; i < 230; i++) begin
            chk("R9 decade carry", d_c_lo, (v % 10 == 9) ? 1 : 0);
            chk("R10 high carry at 99", d_c_hi, (v == 99) ? 1 : 0);
            tick();
            v = (v + 1) % 100;
            chk("R7 decade low digit", d_lo, v % 10);
            chk("R10 two-digit chain", d_hi * 10 + d_lo, v);
        end

        // R9: parallel enable low does not hide carry at 9
        d_load_n = 1'b0; d_din_lo = 4'd9;
        tick();
        d_load_n = 1'b1; d_enp = 1'b0; d_ent = 1'b1;
        #1;
        chk("R9 carry without parallel enable", d_c_lo, 1);
        d_ent = 1'b0;
        #1;
        chk("R9 carry blocked by trickle enable", d_c_lo, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule